// File: doc/BRIEF.md
# Pattern Generator Configuration Register Bank

This block is the register file that sits between a host register bus and the timing logic of a video test-pattern generator. It holds four direct registers: a control byte, a configuration byte, an index byte and a data window. A dozen further registers are reached only through that window. The host first writes an index into the index register. Each later access to the data window then reads or writes the internal register that the index selects. The index stays unchanged until the host writes it again, and it does not advance on its own.

The block decodes the stored bytes into the fields the timing logic needs: the pixel clock divider, the horizontal and vertical total and active sizes, the sync widths, the back porches, the sync polarities, the colour and clock-source selections, the generator enable and the pattern number. The horizontal and vertical totals are 12 bits each, and so are the active sizes. Each pair of 12-bit values is packed into three bytes, and the middle byte is split into two nibbles. All storage clears to zero on reset, so the generator starts disabled.

The register bus is a plain synchronous strobe interface. It has no back-pressure and no wait states. A write strobe takes effect at the clock edge where it is sampled. A read strobe returns its data one cycle later, marked by a one-cycle valid pulse. A strobe may be issued in every cycle, and the host must take each read result in the cycle its valid pulse appears.

Top module: `pgen_cfg_regs`

## Requirements
- R1: After reset every register reads as zero and every decoded output is zero, so `gen_enable` is low.
- R2: Direct address 0x66 is the index register. A write stores the byte, and a read returns the stored byte.
- R3: A read strobe at any direct address gives `bus_rvld` high in the following cycle only, with `bus_rdata` valid in that cycle. A write to 0x67 stores the byte into the indirect register that the current index selects.
- R4: Indices 0x04, 0x05 and 0x06 hold the totals. `h_total` is {idx05[3:0], idx04} and `v_total` is {idx06, idx05[7:4]}, so the bytes 0x98, 0xD4, 0x20 decode to 1176 by 525.
- R5: Indices 0x07, 0x08 and 0x09 hold the active size in the same layout: `h_active` is {idx08[3:0], idx07} and `v_active` is {idx09, idx08[7:4]}.
- R6: Each of these indices holds one whole-byte field: 0x03 is the pixel clock divider, 0x0A is the horizontal sync width, 0x0B is the vertical sync width, 0x0C is the horizontal back porch and 0x0D is the vertical back porch. Without a write, none of the decoded outputs change.
- R7: Index 0x0E holds the polarity bits. Bit 0 sets `hsync_neg` and bit 1 sets `vsync_neg`. Bits 7:2 are not stored and read back as zero.
- R8: Direct address 0x65 is the configuration byte and reads back in full. Bit 0 drives `clk_internal`, bit 1 drives `color_24b` and bit 3 drives `timing_ext_pclk`, so writing 0x03 selects 24-bit colour with the internal clock.
- R9: Direct address 0x64 is the control byte and reads back in full. Bit 0 drives `gen_enable` and bits 7:4 drive `pattern_sel`, so writing 0x11 enables pattern 1.
- R10: Indices outside 0x03 to 0x0E read as zero through the data window. Writes to them change no register and no output.
- R11: Direct addresses other than 0x64 to 0x67 read as zero. Writes to them change no register and no output.
- R12: A read and a write issued together in the same cycle return the value held before that write. The write still takes effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Direct register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvld is high |
| bus_rvld | output | 1 | Read data valid, one cycle after bus_rd |
| gen_enable | output | 1 | Pattern generator enable |
| pattern_sel | output | 4 | Selected pattern number |
| clk_internal | output | 1 | Use the internal pixel clock source |
| color_24b | output | 1 | 24-bit colour (0 selects 18-bit) |
| timing_ext_pclk | output | 1 | Internal timing with external pixel clock |
| pclk_div | output | 8 | Divider applied to the internal clock source |
| h_total | output | 12 | Total pixels per line |
| v_total | output | 12 | Total lines per frame |
| h_active | output | 12 | Active pixels per line |
| v_active | output | 12 | Active lines per frame |
| hsync_width | output | 8 | Horizontal sync width in pixels |
| vsync_width | output | 8 | Vertical sync width in lines |
| hback_porch | output | 8 | Horizontal back porch in pixels |
| vback_porch | output | 8 | Vertical back porch in lines |
| hsync_neg | output | 1 | Horizontal sync is active low |
| vsync_neg | output | 1 | Vertical sync is active low |

## Verification
The packing of the 12-bit fields is tried with three byte patterns.
- A display-like mode of 1176 by 525 catches swapped nibbles in the shared byte.
- An 800 by 480 active size has an empty upper nibble in the shared byte, so a missing shift shows up.
- All-ones bytes give 4095 by 4095, which exposes truncated field widths.

The windowed access is tried against valid indices, against indices just below and just above the mapped range, and against unmapped direct addresses. A read and a write issued in the same cycle separate the old register value from the new one.

// File: rtl/pgen_cfg_pkg.sv
package pgen_cfg_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int FW = 12;

  localparam logic [AW-1:0] A_CTRL = 8'h64;
  localparam logic [AW-1:0] A_CFG  = 8'h65;
  localparam logic [AW-1:0] A_IDX  = 8'h66;
  localparam logic [AW-1:0] A_DATA = 8'h67;

  localparam int IDX_FIRST = 3;
  localparam int IDX_LAST  = 14;
  localparam int N_IND     = IDX_LAST - IDX_FIRST + 1;

  localparam int I_DIV  = 3;
  localparam int I_TOT0 = 4;
  localparam int I_TOT1 = 5;
  localparam int I_TOT2 = 6;
  localparam int I_ACT0 = 7;
  localparam int I_ACT1 = 8;
  localparam int I_ACT2 = 9;
  localparam int I_HSW  = 10;
  localparam int I_VSW  = 11;
  localparam int I_HBP  = 12;
  localparam int I_VBP  = 13;
  localparam int I_POL  = 14;

  localparam logic [DW-1:0] POL_MASK = 8'h03;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_IDX,
    SEL_DATA
  } rd_sel_e;

  typedef struct packed {
    logic [FW-1:0] h_total;
    logic [FW-1:0] v_total;
    logic [FW-1:0] h_active;
    logic [FW-1:0] v_active;
    logic [DW-1:0] div;
    logic [DW-1:0] hsw;
    logic [DW-1:0] vsw;
    logic [DW-1:0] hbp;
    logic [DW-1:0] vbp;
    logic          hs_neg;
    logic          vs_neg;
  } timing_t;
endpackage

// File: rtl/pgen_cfg_decode.sv
module pgen_cfg_decode
  import pgen_cfg_pkg::*;
(
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  output logic          we_ctrl,
  output logic          we_cfg,
  output logic          we_idx,
  output logic          we_data,
  output rd_sel_e       rd_sel
);
  // Address match to a register select; unmatched addresses pick nothing.
  always_comb begin
    unique case (bus_addr)
      A_CTRL:  rd_sel = SEL_CTRL;
      A_CFG:   rd_sel = SEL_CFG;
      A_IDX:   rd_sel = SEL_IDX;
      A_DATA:  rd_sel = SEL_DATA;
      default: rd_sel = SEL_NONE;
    endcase
  end

  assign we_ctrl = bus_wr && (rd_sel == SEL_CTRL);
  assign we_cfg  = bus_wr && (rd_sel == SEL_CFG);
  assign we_idx  = bus_wr && (rd_sel == SEL_IDX);
  assign we_data = bus_wr && (rd_sel == SEL_DATA);
endmodule

// File: rtl/pgen_cfg_indirect.sv
module pgen_cfg_indirect
  import pgen_cfg_pkg::*;
#(
  parameter int FIRST   = IDX_FIRST,
  parameter int LAST    = IDX_LAST,
  parameter int POL_AT  = I_POL,
  localparam int NREG   = LAST - FIRST + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [AW-1:0] MY_IDX = AW'(FIRST + g);
    localparam logic [DW-1:0] MASK   = ((FIRST + g) == POL_AT) ? POL_MASK : {DW{1'b1}};
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (we && (idx == MY_IDX))
        q <= wdata & MASK;
    end
    assign regs_o[g] = q;
  end

  // Window read: indices with no storage return zero.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == AW'(FIRST + i))
        rdata = regs_o[i];
    end
  end
endmodule

// File: rtl/pgen_cfg_unpack.sv
module pgen_cfg_unpack
  import pgen_cfg_pkg::*;
(
  input  logic [N_IND-1:0][DW-1:0] regs,
  output timing_t                  tim
);
  localparam int NIB = DW / 2;

  function automatic logic [DW-1:0] rb(input logic [N_IND-1:0][DW-1:0] r, input int k);
    return r[k - IDX_FIRST];
  endfunction

  logic [DW-1:0] tot_mid, act_mid, pol_byte;
  assign tot_mid  = rb(regs, I_TOT1);
  assign act_mid  = rb(regs, I_ACT1);
  assign pol_byte = rb(regs, I_POL);

  always_comb begin
    tim          = '0;
    tim.h_total  = {tot_mid[NIB-1:0], rb(regs, I_TOT0)};
    tim.v_total  = {rb(regs, I_TOT2), tot_mid[DW-1:NIB]};
    tim.h_active = {act_mid[NIB-1:0], rb(regs, I_ACT0)};
    tim.v_active = {rb(regs, I_ACT2), act_mid[DW-1:NIB]};
    tim.div      = rb(regs, I_DIV);
    tim.hsw      = rb(regs, I_HSW);
    tim.vsw      = rb(regs, I_VSW);
    tim.hbp      = rb(regs, I_HBP);
    tim.vbp      = rb(regs, I_VBP);
    tim.hs_neg   = pol_byte[0];
    tim.vs_neg   = pol_byte[1];
  end

  logic unused_pol_hi;
  assign unused_pol_hi = ^pol_byte[DW-1:2];
endmodule

// File: rtl/pgen_cfg_regs.sv
module pgen_cfg_regs
  import pgen_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_rvld,
  output logic          gen_enable,
  output logic [3:0]    pattern_sel,
  output logic          clk_internal,
  output logic          color_24b,
  output logic          timing_ext_pclk,
  output logic [7:0]    pclk_div,
  output logic [11:0]   h_total,
  output logic [11:0]   v_total,
  output logic [11:0]   h_active,
  output logic [11:0]   v_active,
  output logic [7:0]    hsync_width,
  output logic [7:0]    vsync_width,
  output logic [7:0]    hback_porch,
  output logic [7:0]    vback_porch,
  output logic          hsync_neg,
  output logic          vsync_neg
);
  logic                     we_ctrl, we_cfg, we_idx, we_data;
  rd_sel_e                  rd_sel;
  logic [DW-1:0]            ctrl_q, cfg_q, idx_q;
  logic [DW-1:0]            win_rdata, rd_mux, rdata_q;
  logic                     rvld_q;
  logic [N_IND-1:0][DW-1:0] ind_regs;
  timing_t                  tim;

  pgen_cfg_decode u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .we_ctrl  (we_ctrl),
    .we_cfg   (we_cfg),
    .we_idx   (we_idx),
    .we_data  (we_data),
    .rd_sel   (rd_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= bus_wdata;
      if (we_cfg)  cfg_q  <= bus_wdata;
      if (we_idx)  idx_q  <= bus_wdata;
    end
  end

  pgen_cfg_indirect u_ind (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we_data),
    .idx    (idx_q),
    .wdata  (bus_wdata),
    .rdata  (win_rdata),
    .regs_o (ind_regs)
  );

  pgen_cfg_unpack u_unp (
    .regs (ind_regs),
    .tim  (tim)
  );

  // Read mux sees pre-write state, so a same-cycle write is not forwarded.
  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_CFG:  rd_mux = cfg_q;
      SEL_IDX:  rd_mux = idx_q;
      SEL_DATA: rd_mux = win_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q  <= bus_rd;
      rdata_q <= bus_rd ? rd_mux : '0;
    end
  end

  assign bus_rdata       = rdata_q;
  assign bus_rvld        = rvld_q;
  assign gen_enable      = ctrl_q[0];
  assign pattern_sel     = ctrl_q[7:4];
  assign clk_internal    = cfg_q[0];
  assign color_24b       = cfg_q[1];
  assign timing_ext_pclk = cfg_q[3];
  assign pclk_div        = tim.div;
  assign h_total         = tim.h_total;
  assign v_total         = tim.v_total;
  assign h_active        = tim.h_active;
  assign v_active        = tim.v_active;
  assign hsync_width     = tim.hsw;
  assign vsync_width     = tim.vsw;
  assign hback_porch     = tim.hbp;
  assign vback_porch     = tim.vbp;
  assign hsync_neg       = tim.hs_neg;
  assign vsync_neg       = tim.vs_neg;
endmodule

// File: rtl/pgen_cfg_regs_chk.sv
module pgen_cfg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        bus_rvld,
  input logic [7:0]  idx_q,
  input logic        gen_enable,
  input logic [3:0]  pattern_sel,
  input logic        hsync_neg,
  input logic        vsync_neg,
  input logic [11:0] h_total,
  input logic [11:0] v_total,
  input logic [7:0]  hback_porch
);
  logic win_wr, idx_unmapped, addr_unmapped;
  assign win_wr        = bus_wr && (bus_addr == 8'h67);
  assign idx_unmapped  = (idx_q < 8'h03) || (idx_q > 8'h0E);
  assign addr_unmapped = (bus_addr < 8'h64) || (bus_addr > 8'h67);

  p_rvld_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvld);

  p_rvld_only_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvld);

  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(h_total) && $stable(v_total) && $stable(hback_porch)
                 && $stable(gen_enable) && $stable(hsync_neg)));

  p_unmapped_idx_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_unmapped) |=> ($stable(h_total) && $stable(v_total)
                                  && $stable(hback_porch) && $stable(hsync_neg)));

  p_unmapped_addr_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr_unmapped) |=> (bus_rdata == 8'h00));

  p_polarity_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_q == 8'h0E) |=> (hsync_neg == $past(bus_wdata[0])
                                   && vsync_neg == $past(bus_wdata[1])));

  p_ctrl_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h64) |=> (gen_enable == $past(bus_wdata[0])
                                      && pattern_sel == $past(bus_wdata[7:4])));
endmodule

bind pgen_cfg_regs pgen_cfg_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .bus_rvld    (bus_rvld),
  .idx_q       (idx_q),
  .gen_enable  (gen_enable),
  .pattern_sel (pattern_sel),
  .hsync_neg   (hsync_neg),
  .vsync_neg   (vsync_neg),
  .h_total     (h_total),
  .v_total     (v_total),
  .hback_porch (hback_porch)
);

// File: tb/test_pgen_cfg_regs.sv
`timescale 1ns/1ps
module test_pgen_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvld;
  logic        gen_enable, clk_internal, color_24b, timing_ext_pclk;
  logic [3:0]  pattern_sel;
  logic [7:0]  pclk_div, hsync_width, vsync_width, hback_porch, vback_porch;
  logic [11:0] h_total, v_total, h_active, v_active;
  logic        hsync_neg, vsync_neg;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  pgen_cfg_regs i_pgen_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvld(bus_rvld), .gen_enable(gen_enable), .pattern_sel(pattern_sel),
    .clk_internal(clk_internal), .color_24b(color_24b),
    .timing_ext_pclk(timing_ext_pclk), .pclk_div(pclk_div),
    .h_total(h_total), .v_total(v_total), .h_active(h_active), .v_active(v_active),
    .hsync_width(hsync_width), .vsync_width(vsync_width),
    .hback_porch(hback_porch), .vback_porch(vback_porch),
    .hsync_neg(hsync_neg), .vsync_neg(vsync_neg)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles got %0d expected below %0d", cyc, 100000);
      summary();
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvld;
  endtask

  task automatic iwr(input logic [7:0] i, input logic [7:0] d);
    wr(8'h66, i);
    wr(8'h67, d);
  endtask

  task automatic ird(input logic [7:0] i, output logic [7:0] d);
    logic v;
    wr(8'h66, i);
    rd(8'h67, d, v);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    check("R1 gen_enable", gen_enable, 0);
    check("R1 h_total", h_total, 0);
    check("R1 v_active", v_active, 0);
    check("R1 pclk_div", pclk_div, 0);
    check("R1 hsync_neg", hsync_neg, 0);
    rd(8'h64, d, v); check("R1 ctrl read", d, 0);
    rd(8'h65, d, v); check("R1 cfg read", d, 0);
    for (int i = 3; i <= 14; i++) begin
      ird(8'(i), d); check($sformatf("R1 idx %0d read", i), d, 0);
    end
  endtask

  task automatic t_index();
    logic [7:0] d; logic v;
    wr(8'h66, 8'h5A);
    rd(8'h66, d, v);
    check("R2 index readback", d, 8'h5A);
    check("R3 rvld after read", v, 1);
    @(negedge clk);
    check("R3 rvld single cycle", bus_rvld, 0);
  endtask

  task automatic t_total();
    logic [7:0] d;
    iwr(8'h04, 8'h98); iwr(8'h05, 8'hD4); iwr(8'h06, 8'h20);
    check("R4 h_total 1176", h_total, 1176);
    check("R4 v_total 525", v_total, 525);
    ird(8'h05, d); check("R3 window read idx 05", d, 8'hD4);
    iwr(8'h04, 8'hFF); iwr(8'h05, 8'hFF); iwr(8'h06, 8'hFF);
    check("R4 h_total max", h_total, 4095);
    check("R4 v_total max", v_total, 4095);
    iwr(8'h04, 8'h98); iwr(8'h05, 8'hD4); iwr(8'h06, 8'h20);
  endtask

  task automatic t_active();
    iwr(8'h07, 8'h20); iwr(8'h08, 8'h03); iwr(8'h09, 8'h1E);
    check("R5 h_active 800", h_active, 800);
    check("R5 v_active 480", v_active, 480);
    iwr(8'h08, 8'hA5);
    check("R5 h_active nibble", h_active, 12'h520);
    check("R5 v_active nibble", v_active, 12'h1EA);
  endtask

  task automatic t_singles();
    iwr(8'h03, 8'h06); iwr(8'h0A, 8'h0A); iwr(8'h0B, 8'h02);
    iwr(8'h0C, 8'hD8); iwr(8'h0D, 8'h23);
    check("R6 pclk_div", pclk_div, 6);
    check("R6 hsync_width", hsync_width, 10);
    check("R6 vsync_width", vsync_width, 2);
    check("R6 hback_porch", hback_porch, 8'hD8);
    check("R6 vback_porch", vback_porch, 8'h23);
    repeat (3) @(negedge clk);
    check("R6 hold without write", h_total, 1176);
  endtask

  task automatic t_polarity();
    logic [7:0] d;
    iwr(8'h0E, 8'h03);
    check("R7 hsync_neg", hsync_neg, 1);
    check("R7 vsync_neg", vsync_neg, 1);
    iwr(8'h0E, 8'hFE);
    check("R7 hsync_neg clear", hsync_neg, 0);
    check("R7 vsync_neg set", vsync_neg, 1);
    ird(8'h0E, d); check("R7 upper bits dropped", d, 8'h02);
  endtask

  task automatic t_cfg_ctrl();
    logic [7:0] d; logic v;
    wr(8'h65, 8'h03);
    check("R8 clk_internal", clk_internal, 1);
    check("R8 color_24b", color_24b, 1);
    check("R8 timing_ext_pclk off", timing_ext_pclk, 0);
    wr(8'h65, 8'hF8);
    check("R8 timing_ext_pclk", timing_ext_pclk, 1);
    check("R8 clk_internal off", clk_internal, 0);
    rd(8'h65, d, v); check("R8 cfg readback", d, 8'hF8);
    wr(8'h64, 8'h11);
    check("R9 gen_enable", gen_enable, 1);
    check("R9 pattern_sel", pattern_sel, 1);
    rd(8'h64, d, v); check("R9 ctrl readback", d, 8'h11);
  endtask

  task automatic t_unmapped_idx();
    logic [7:0] d;
    iwr(8'h0F, 8'h55); ird(8'h0F, d); check("R10 idx 0F reads zero", d, 0);
    iwr(8'h02, 8'h77); ird(8'h02, d); check("R10 idx 02 reads zero", d, 0);
    iwr(8'hFF, 8'h12); ird(8'hFF, d); check("R10 idx FF reads zero", d, 0);
    check("R10 h_total untouched", h_total, 1176);
    check("R10 pclk_div untouched", pclk_div, 6);
    check("R10 polarity untouched", {vsync_neg, hsync_neg}, 2'b10);
    ird(8'h0E, d); check("R10 neighbour 0E", d, 8'h02);
    ird(8'h03, d); check("R10 neighbour 03", d, 8'h06);
  endtask

  task automatic t_unmapped_addr();
    logic [7:0] d; logic v;
    wr(8'h63, 8'h00); wr(8'h68, 8'h00); wr(8'h00, 8'hFF);
    rd(8'h68, d, v); check("R11 addr 68 reads zero", d, 0);
    check("R11 rvld on unmapped", v, 1);
    rd(8'h63, d, v); check("R11 addr 63 reads zero", d, 0);
    check("R11 gen_enable untouched", gen_enable, 1);
    check("R11 cfg untouched", timing_ext_pclk, 1);
    rd(8'h64, d, v); check("R11 ctrl untouched", d, 8'h11);
  endtask

  task automatic t_same_cycle();
    wr(8'h66, 8'h0C);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h67; bus_wdata = 8'h44;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R12 read returns old", bus_rdata, 8'hD8);
    check("R12 rvld", bus_rvld, 1);
    check("R12 write landed", hback_porch, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_total();
    t_active();
    t_singles();
    t_polarity();
    t_cfg_ctrl();
    t_unmapped_idx();
    t_unmapped_addr();
    t_same_cycle();
    summary();
  end
endmodule